// File: doc/BRIEF.md
# Programmable Edge/Level Trigger Conditioner

This block sits between a bank of raw interrupt pins (64 by default) and the downstream interrupt controllers. It turns each pin into a conditioned request line. Each line has one of four sensing modes: rising edge, falling edge, active-high level or active-low level. Two independent configuration bits select the mode, a "rise" bit and a "fall" bit. Every pin first passes through a two-flop synchroniser. In the edge modes a detected transition sets a sticky pending bit, which stays set until software acknowledges it. In the level modes the synchronised pin goes straight to the output, inverted when the mode is active low.

Software reaches the block through a simple word-addressed register port. The lines are split into 32-line halves. Each half has eight word registers at the same relative positions, and the higher half sits eight words (0x20 bytes) above the lower one. Each configuration bit has a direct-write register, a write-one-to-set alias and a write-one-to-clear alias. A write of ones to the raw-status word acknowledges pending edges.

Top module: `trig_conditioner`

## Requirements
- R1: After reset every rise and fall configuration bit is 0, so every line is in active-high level mode. No edge is pending, and with low pins every request output is 0.
- R2: With rise=0 and fall=0 (active-high level) the request output equals the pin. It follows the pin exactly two clock edges after a change.
- R3: With rise=1 and fall=1 (active-low level) the request output is the inverse of the synchronised pin.
- R4: With rise=1 and fall=0 a low-to-high transition of the synchronised pin sets the line's pending bit. The request stays 1 after the pin returns low, until an acknowledge arrives.
- R5: With rise=0 and fall=1 a high-to-low transition sets the pending bit, and a low-to-high transition does not.
- R6: A write to word 1 of a half (raw status) clears the pending bit of each line whose data bit is 1. Data bits of 0 leave pending bits alone, and the write has no effect on level-mode lines.
- R7: If an acknowledge and a new qualifying edge on the same line fall in the same cycle, the pending bit stays 1.
- R8: Word registers per half: 0 status, 1 raw status, 2 rise config, 3 fall config, 4 rise-set, 5 rise-clear, 6 fall-set, 7 fall-clear. Words 2 and 3 are written directly. In words 4 to 7 each 1 data bit sets or clears the matching config bit, and each 0 data bit leaves it unchanged. Words 4 to 7 read as 0.
- R9: Word address bit 3 selects the half. Lines 32 to 63 use words 8 to 15, with line 32+k at data bit k, and writes to one half never touch the other.
- R10: Status (word 0) reads the request outputs. Raw status (word 1) reads the pending bit for edge-mode lines and the uninverted synchronised pin for level-mode lines.
- R11: A line that is switched to a level mode drops its pending bit. Returning it to an edge mode later shows no stale event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | LINES | Raw asynchronous interrupt pins |
| bus_wr | input | 1 | Register write strobe, one word per cycle |
| bus_word | input | ADDR_W | Word address (byte offset divided by 4) within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word, combinational |
| req_out | output | LINES | Conditioned request lines |

## Verification
The bench targets the collision of an acknowledge with a fresh edge in the same cycle. A design that gave the clear priority would lose the second event. It checks synchroniser latency at the exact edge, where an extra or a missing stage shifts the output by a cycle. It confirms that a rising transition on a falling-edge line latches nothing, which catches a design that treats rise=1, fall=1 or either bit as a both-edge detector. It also checks that half selection and alias zero bits leave unrelated lines untouched, and that a line leaving edge mode forgets its pending event instead of replaying it on return.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned IDX_W      = 3;
    localparam int unsigned DEF_LINES  = 64;
    localparam int unsigned SYNC_DEPTH = 2;

    // Word index inside one half; software decodes these positions.
    typedef enum logic [IDX_W-1:0] {
        IDX_STATUS   = 3'd0,
        IDX_RAW      = 3'd1,
        IDX_RISE     = 3'd2,
        IDX_FALL     = 3'd3,
        IDX_RISE_SET = 3'd4,
        IDX_RISE_CLR = 3'd5,
        IDX_FALL_SET = 3'd6,
        IDX_FALL_CLR = 3'd7
    } reg_idx_e;

    // Encoded as {rise, fall}.
    typedef enum logic [1:0] {
        MODE_LEVEL_HIGH = 2'b00,
        MODE_FALL_EDGE  = 2'b01,
        MODE_RISE_EDGE  = 2'b10,
        MODE_LEVEL_LOW  = 2'b11
    } trig_mode_e;

    typedef struct packed {
        logic is_edge;
        logic want_rise;
        logic invert;
    } line_ctl_t;

    function automatic line_ctl_t decode_mode(input logic rise, input logic fall);
        line_ctl_t c;
        c = '0;
        case (trig_mode_e'({rise, fall}))
            MODE_RISE_EDGE:  begin c.is_edge = 1'b1; c.want_rise = 1'b1; end
            MODE_FALL_EDGE:  begin c.is_edge = 1'b1; c.want_rise = 1'b0; end
            MODE_LEVEL_LOW:  c.invert = 1'b1;
            default:         c.invert = 1'b0;
        endcase
        return c;
    endfunction

    function automatic int unsigned sel_width(input int unsigned halves);
        return (halves > 1) ? $clog2(halves) : 1;
    endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int unsigned WIDTH  = 64,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank
    import trig_cond_pkg::*;
#(
    parameter int unsigned LINES  = 64,
    localparam int unsigned HALVES = LINES / WORD_W,
    localparam int unsigned HSEL_W = sel_width(HALVES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [HSEL_W-1:0] half_sel,
    input  reg_idx_e          idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [LINES-1:0]  rise_cfg,
    output logic [LINES-1:0]  fall_cfg,
    output logic [LINES-1:0]  ack_vec
);
    for (genvar h = 0; h < int'(HALVES); h++) begin : g_half
        logic hit;
        assign hit = wr && (half_sel == HSEL_W'(h));

        always_ff @(posedge clk) begin
            if (rst) begin
                rise_cfg[h*WORD_W +: WORD_W] <= '0;
                fall_cfg[h*WORD_W +: WORD_W] <= '0;
            end else if (hit) begin
                case (idx)
                    IDX_RISE:     rise_cfg[h*WORD_W +: WORD_W] <= wdata;
                    IDX_FALL:     fall_cfg[h*WORD_W +: WORD_W] <= wdata;
                    IDX_RISE_SET: rise_cfg[h*WORD_W +: WORD_W] <= rise_cfg[h*WORD_W +: WORD_W] | wdata;
                    IDX_RISE_CLR: rise_cfg[h*WORD_W +: WORD_W] <= rise_cfg[h*WORD_W +: WORD_W] & ~wdata;
                    IDX_FALL_SET: fall_cfg[h*WORD_W +: WORD_W] <= fall_cfg[h*WORD_W +: WORD_W] | wdata;
                    IDX_FALL_CLR: fall_cfg[h*WORD_W +: WORD_W] <= fall_cfg[h*WORD_W +: WORD_W] & ~wdata;
                    default: ;
                endcase
            end
        end

        assign ack_vec[h*WORD_W +: WORD_W] = (hit && idx == IDX_RAW) ? wdata : '0;
    end
endmodule

// File: rtl/trig_line.sv
module trig_line
    import trig_cond_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic rise_en,
    input  logic fall_en,
    input  logic ack,
    output logic req,
    output logic raw
);
    line_ctl_t ctl;
    logic      prev_q;
    logic      pend_q;
    logic      pend_d;
    logic      hit;

    assign ctl = decode_mode(rise_en, fall_en);
    assign hit = ctl.is_edge &
                 (ctl.want_rise ? (sync_in & ~prev_q) : (~sync_in & prev_q));

    // A new edge wins over an acknowledge in the same cycle.
    assign pend_d = ctl.is_edge ? ((pend_q & ~ack) | hit) : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= sync_in;
            pend_q <= pend_d;
        end
    end

    assign req = ctl.is_edge ? pend_q : (sync_in ^ ctl.invert);
    assign raw = ctl.is_edge ? pend_q : sync_in;
endmodule

// File: rtl/trig_conditioner.sv
module trig_conditioner
    import trig_cond_pkg::*;
#(
    parameter int unsigned LINES  = DEF_LINES,
    parameter int unsigned STAGES = SYNC_DEPTH,
    localparam int unsigned HALVES = LINES / WORD_W,
    localparam int unsigned HSEL_W = sel_width(HALVES),
    localparam int unsigned ADDR_W = IDX_W + HSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  pin_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_word,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [LINES-1:0]  req_out
);
    logic [LINES-1:0]  pin_sync;
    logic [LINES-1:0]  rise_cfg;
    logic [LINES-1:0]  fall_cfg;
    logic [LINES-1:0]  ack_vec;
    logic [LINES-1:0]  raw_vec;
    logic [HSEL_W-1:0] half_sel;
    reg_idx_e          idx;

    assign half_sel = bus_word[ADDR_W-1:IDX_W];
    assign idx      = reg_idx_e'(bus_word[IDX_W-1:0]);

    trig_sync #(.WIDTH(LINES), .STAGES(STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    trig_cfg_bank #(.LINES(LINES)) i_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .half_sel (half_sel),
        .idx      (idx),
        .wdata    (bus_wdata),
        .rise_cfg (rise_cfg),
        .fall_cfg (fall_cfg),
        .ack_vec  (ack_vec)
    );

    for (genvar n = 0; n < int'(LINES); n++) begin : g_line
        trig_line i_line (
            .clk     (clk),
            .rst     (rst),
            .sync_in (pin_sync[n]),
            .rise_en (rise_cfg[n]),
            .fall_en (fall_cfg[n]),
            .ack     (ack_vec[n]),
            .req     (req_out[n]),
            .raw     (raw_vec[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int h = 0; h < int'(HALVES); h++) begin
            if (half_sel == HSEL_W'(h)) begin
                case (idx)
                    IDX_STATUS: bus_rdata = req_out[h*WORD_W +: WORD_W];
                    IDX_RAW:    bus_rdata = raw_vec[h*WORD_W +: WORD_W];
                    IDX_RISE:   bus_rdata = rise_cfg[h*WORD_W +: WORD_W];
                    IDX_FALL:   bus_rdata = fall_cfg[h*WORD_W +: WORD_W];
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/trig_conditioner_chk.sv
module trig_conditioner_chk
    import trig_cond_pkg::*;
#(
    parameter int unsigned LINES  = 64,
    localparam int unsigned HALVES = LINES / WORD_W,
    localparam int unsigned HSEL_W = sel_width(HALVES),
    localparam int unsigned ADDR_W = IDX_W + HSEL_W
) (
    input logic              clk,
    input logic              rst,
    input logic [LINES-1:0]  pin_in,
    input logic [LINES-1:0]  req_out,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_word,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [LINES-1:0]  rise_cfg,
    input logic [LINES-1:0]  fall_cfg
);
    logic [1:0]       age;
    logic             warm;
    logic [LINES-1:0] ackv, rsetv, rclrv;
    logic [LINES-1:0] lvl_hi, lvl_lo, edge_m;

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end
    assign warm = (age == 2'd3);

    always_comb begin
        ackv  = '0;
        rsetv = '0;
        rclrv = '0;
        for (int h = 0; h < int'(HALVES); h++) begin
            if (bus_wr && bus_word[ADDR_W-1:IDX_W] == HSEL_W'(h)) begin
                if (bus_word[IDX_W-1:0] == 3'd1) ackv[h*WORD_W +: WORD_W]  = bus_wdata;
                if (bus_word[IDX_W-1:0] == 3'd4) rsetv[h*WORD_W +: WORD_W] = bus_wdata;
                if (bus_word[IDX_W-1:0] == 3'd5) rclrv[h*WORD_W +: WORD_W] = bus_wdata;
            end
        end
    end

    assign lvl_hi = ~rise_cfg & ~fall_cfg;
    assign lvl_lo = rise_cfg & fall_cfg;
    assign edge_m = rise_cfg ^ fall_cfg;

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (rise_cfg == '0 && fall_cfg == '0 && req_out == '0));

    // R2
    a_r2_level_high_follows: assert property (@(posedge clk) disable iff (rst)
        warm |-> (((req_out ^ $past(pin_in, 2)) & lvl_hi) == '0));

    // R3
    a_r3_level_low_inverts: assert property (@(posedge clk) disable iff (rst)
        warm |-> (((req_out ^ ~$past(pin_in, 2)) & lvl_lo) == '0));

    // R4 / R6: pending edge only drops on an acknowledge
    a_r4_sticky_until_ack: assert property (@(posedge clk) disable iff (rst)
        warm |-> (($past(req_out) & $past(edge_m) & edge_m & ~req_out & ~$past(ackv)) == '0));

    // R8
    a_r8_rise_set_alias: assert property (@(posedge clk) disable iff (rst)
        warm |-> (($past(rsetv) & ~rise_cfg) == '0));

    // R8
    a_r8_rise_clr_alias: assert property (@(posedge clk) disable iff (rst)
        warm |-> (($past(rclrv) & rise_cfg) == '0));
endmodule

bind trig_conditioner trig_conditioner_chk #(.LINES(LINES)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pin_in),
    .req_out   (req_out),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .rise_cfg  (rise_cfg),
    .fall_cfg  (fall_cfg)
);

// File: tb/test_trig_conditioner.sv
`timescale 1ns/1ps
module test_trig_conditioner;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] pin_in = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] req_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    trig_conditioner i_trig_conditioner (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pin_in),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .req_out   (req_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] w, input logic [31:0] d);
        bus_word  = w;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] w, output logic [31:0] d);
        bus_word = w;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 req after reset", req_out, 64'h0);
        bus_read(4'd2, d); check("R1 rise cfg lo", {32'h0, d}, 64'h0);
        bus_read(4'd11, d); check("R1 fall cfg hi", {32'h0, d}, 64'h0);
    endtask

    task automatic t_aliases();
        logic [31:0] d;
        bus_write(4'd4, 32'h0000_0F00);
        bus_read(4'd2, d); check("R8 rise-set", {32'h0, d}, 64'h0F00);
        bus_write(4'd5, 32'h0000_0300);
        bus_read(4'd2, d); check("R8 rise-clear", {32'h0, d}, 64'h0C00);
        bus_write(4'd5, 32'h0);
        bus_read(4'd2, d); check("R8 zero bits ignored", {32'h0, d}, 64'h0C00);
        bus_read(4'd4, d); check("R8 alias reads zero", {32'h0, d}, 64'h0);
        bus_write(4'd3, 32'h0000_00A5);
        bus_read(4'd3, d); check("R8 fall direct write", {32'h0, d}, 64'hA5);
        bus_write(4'd7, 32'h0000_00FF);
        bus_write(4'd2, 32'h0);
        bus_read(4'd3, d); check("R8 fall-clear", {32'h0, d}, 64'h0);
    endtask

    task automatic t_level_high();
        logic [31:0] d;
        pin_in[5] = 1'b1;
        wait_cycles(1);
        check("R2 one edge after change", {63'h0, req_out[5]}, 64'h0);
        wait_cycles(1);
        check("R2 two edges after change", {63'h0, req_out[5]}, 64'h1);
        bus_read(4'd1, d); check("R10 raw live level", {63'h0, d[5]}, 64'h1);
        bus_read(4'd0, d); check("R10 status matches req", {32'h0, d}, {32'h0, req_out[31:0]});
    endtask

    task automatic t_level_low();
        logic [31:0] d;
        bus_write(4'd4, 32'h80);
        bus_write(4'd6, 32'h80);
        wait_cycles(1);
        check("R3 low pin gives request", {63'h0, req_out[7]}, 64'h1);
        bus_read(4'd1, d); check("R10 raw uninverted", {63'h0, d[7]}, 64'h0);
        pin_in[7] = 1'b1;
        wait_cycles(3);
        check("R3 high pin drops request", {63'h0, req_out[7]}, 64'h0);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        bus_write(4'd4, 32'h1000);
        bus_write(4'd7, 32'h1000);
        pin_in[12] = 1'b1;
        wait_cycles(4);
        check("R4 rising edge latched", {63'h0, req_out[12]}, 64'h1);
        pin_in[12] = 1'b0;
        wait_cycles(4);
        check("R4 sticky after pin low", {63'h0, req_out[12]}, 64'h1);
        bus_read(4'd1, d); check("R10 raw shows pending", {63'h0, d[12]}, 64'h1);
    endtask

    task automatic t_ack();
        bus_write(4'd1, 32'h0);
        check("R6 zero ack ignored", {63'h0, req_out[12]}, 64'h1);
        bus_write(4'd1, 32'h1000);
        check("R6 ack clears", {63'h0, req_out[12]}, 64'h0);
    endtask

    task automatic t_fall();
        bus_write(4'd6, 32'h2000);
        pin_in[13] = 1'b1;
        wait_cycles(4);
        check("R5 rise ignored on falling line", {63'h0, req_out[13]}, 64'h0);
        pin_in[13] = 1'b0;
        wait_cycles(4);
        check("R5 falling edge latched", {63'h0, req_out[13]}, 64'h1);
        bus_write(4'd1, 32'hFFFF_FFFF);
        check("R6 all-ones ack", {62'h0, req_out[13], req_out[12]}, 64'h0);
        check("R6 level line unaffected", {63'h0, req_out[5]}, 64'h1);
    endtask

    task automatic t_collision();
        bus_write(4'd4, 32'h4000);
        pin_in[14] = 1'b1;
        wait_cycles(4);
        pin_in[14] = 1'b0;
        wait_cycles(4);
        check("R7 first edge pending", {63'h0, req_out[14]}, 64'h1);
        pin_in[14] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_write(4'd1, 32'h4000);
        check("R7 edge wins over ack", {63'h0, req_out[14]}, 64'h1);
        bus_write(4'd1, 32'h4000);
        check("R7 later ack clears", {63'h0, req_out[14]}, 64'h0);
    endtask

    task automatic t_high_half();
        logic [31:0] d;
        bus_write(4'd12, 32'h100);
        bus_read(4'd10, d); check("R9 rise cfg high half", {32'h0, d}, 64'h100);
        bus_read(4'd2, d);  check("R9 low half untouched", {32'h0, d}, 64'h5080);
        pin_in[40] = 1'b1;
        wait_cycles(4);
        check("R9 line 40 latched", {62'h0, req_out[40], req_out[8]}, 64'h2);
        bus_read(4'd9, d); check("R9 raw high half", {63'h0, d[8]}, 64'h1);
        bus_write(4'd1, 32'h100);
        check("R9 low-half ack misses line 40", {63'h0, req_out[40]}, 64'h1);
        bus_write(4'd9, 32'h100);
        check("R9 high-half ack", {63'h0, req_out[40]}, 64'h0);
    endtask

    task automatic t_mode_leave();
        pin_in[40] = 1'b0;
        wait_cycles(4);
        pin_in[40] = 1'b1;
        wait_cycles(4);
        pin_in[40] = 1'b0;
        wait_cycles(4);
        check("R11 pending before mode change", {63'h0, req_out[40]}, 64'h1);
        bus_write(4'd13, 32'h100);
        check("R11 level mode shows pin", {63'h0, req_out[40]}, 64'h0);
        bus_write(4'd12, 32'h100);
        check("R11 no stale event on return", {63'h0, req_out[40]}, 64'h0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wait_cycles(1);
        t_reset();
        t_aliases();
        t_level_high();
        t_level_low();
        t_rise();
        t_ack();
        t_fall();
        t_collision();
        t_high_half();
        t_mode_leave();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule